// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic/Logic Slice

This block is a purely combinational arithmetic/logic slice. It has two operand words, a three-bit function code and a carry input, and it forms a result word from them. The function codes cover three kinds of operation. There are three arithmetic operations: a sum and a difference taken in either direction. There are three bitwise logic operations. There are two constant outputs. Bit 0 is the least significant bit of every data word, and all data is active-high.

Several slices can be joined to make a wider datapath. A parameter selects which cascade outputs a slice drives:

- The ripple variant passes its carry out of the top bit straight to the next slice. It also reports signed two's-complement overflow.
- The look-ahead variant drives active-low group propagate and group generate signals. An external carry tree uses them.

During subtraction the carry means "no borrow". The lowest slice therefore takes a carry-in of 1 for a plain difference.

Top module: `alu_slice`

## Requirements
- R1: With func_sel = 3'b011, result equals the low 4 bits of A + B + carry_in. Bit 0 is the least significant bit.
- R2: With func_sel = 3'b001, the adder operands are x = B and y = ~A. Result equals the low bits of B + ~A + carry_in, which is B minus A when carry_in is 1.
- R3: With func_sel = 3'b010, the adder operands are x = A and y = ~B. Result equals the low bits of A + ~B + carry_in.
- R4: In the ripple variant, on the arithmetic codes 001, 010 and 011, carry_out is bit 4 of x + y + carry_in. For a subtraction with carry_in = 1, carry_out is 1 exactly when no borrow occurs.
- R5: Codes 100, 101 and 110 give the bitwise XOR, OR and AND of A and B, in that order.
- R6: Code 000 gives result 0000 and code 111 gives result 1111.
- R7: On every non-arithmetic code (000, 100, 101, 110, 111), carry_out is 0, ovf_out is 0, and grp_prop_n and grp_gen_n are 1.
- R8: In the ripple variant on arithmetic codes, ovf_out is 1 exactly when the signed sum of x, y and carry_in lies outside -8..7.
- R9: In the look-ahead variant on arithmetic codes, grp_gen_n is 0 exactly when x + y (carry_in ignored) is 16 or more.
- R10: In the look-ahead variant on arithmetic codes, grp_prop_n is 0 exactly when (x | y) equals 1111. The carry out of the top bit then equals generate OR (propagate AND carry_in).
- R11: The ripple variant holds grp_prop_n and grp_gen_n at 1. The look-ahead variant holds carry_out and ovf_out at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | Operand A |
| opnd_b | input | 4 | Operand B |
| func_sel | input | 3 | Function code |
| carry_in | input | 1 | Carry input (no-borrow when subtracting) |
| result | output | 4 | Result word |
| carry_out | output | 1 | Ripple carry out of bit 3 (ripple variant) |
| ovf_out | output | 1 | Signed overflow (ripple variant) |
| grp_prop_n | output | 1 | Active-low group propagate (look-ahead variant) |
| grp_gen_n | output | 1 | Active-low group generate (look-ahead variant) |

## Verification
Carry-out and signed overflow can both be raised by the same operation. Adding two large negative values, such as 1000 + 1000, produces both at once. So can a subtraction that crosses the sign boundary. The same holds for group propagate and generate, which are both asserted when x | y is all ones and x + y wraps.

The sweep runs every operand pair with both carry-in values on every code. This reaches all four combinations of each pair. Each flag is then judged on its own against a separate arithmetic rule: carry from the unsigned sum, overflow from the signed range, generate from the sum taken without the carry-in, and propagate from the bitwise OR.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR  = 3'b000,
    OP_B_SUBA = 3'b001,
    OP_A_SUBB = 3'b010,
    OP_ADD    = 3'b011,
    OP_XOR    = 3'b100,
    OP_OR     = 3'b101,
    OP_AND    = 3'b110,
    OP_SET    = 3'b111
  } alu_op_e;

  function automatic logic op_is_arith(input logic [2:0] code);
    return (code == OP_B_SUBA) || (code == OP_A_SUBB) || (code == OP_ADD);
  endfunction

  function automatic logic op_is_bitwise(input logic [2:0] code);
    return (code == OP_XOR) || (code == OP_OR) || (code == OP_AND);
  endfunction

endpackage

// File: rtl/alu_slice_operand.sv
module alu_slice_operand
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       func_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] add_x,
  output logic [WIDTH-1:0] add_y,
  output logic             arith_en
);

  always_comb begin
    arith_en = op_is_arith(func_sel);
    unique case (func_sel)
      OP_B_SUBA: begin add_x = opnd_b; add_y = ~opnd_a; end
      OP_A_SUBB: begin add_x = opnd_a; add_y = ~opnd_b; end
      OP_ADD:    begin add_x = opnd_a; add_y = opnd_b;  end
      default:   begin add_x = '0;     add_y = '0;      end
    endcase
  end

  // R2
  always_comb begin
    if (func_sel == OP_B_SUBA) begin
      swap_order_chk: assert ((add_x == opnd_b) && ((add_y ^ opnd_a) == {WIDTH{1'b1}}))
        else $error("minuend/subtrahend routing wrong for B minus A");
    end
  end

endmodule

// File: rtl/alu_slice_adder.sv
module alu_slice_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] add_x,
  input  logic [WIDTH-1:0] add_y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry_top,
  output logic             carry_msb_in,
  output logic             grp_p,
  output logic             grp_g
);

  logic [WIDTH:0]   rc;
  logic [WIDTH:0]   gc;
  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] bit_g;

  assign rc[0] = cin;
  assign gc[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_p[i]  = add_x[i] | add_y[i];
    assign bit_g[i]  = add_x[i] & add_y[i];
    assign sum[i]    = add_x[i] ^ add_y[i] ^ rc[i];
    assign rc[i+1]   = bit_g[i] | ((add_x[i] ^ add_y[i]) & rc[i]);
    assign gc[i+1]   = bit_g[i] | (bit_p[i] & gc[i]);
  end

  assign carry_top    = rc[WIDTH];
  assign carry_msb_in = rc[WIDTH-1];
  assign grp_p        = &bit_p;
  assign grp_g        = gc[WIDTH];

  // R10
  always_comb begin
    carry_lookahead_chk: assert (carry_top == (grp_g | (grp_p & cin)))
      else $error("ripple carry disagrees with group propagate/generate");
  end

endmodule

// File: rtl/alu_slice_logic.sv
module alu_slice_logic
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       func_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] logic_res
);

  always_comb begin
    unique case (func_sel)
      OP_XOR:  logic_res = opnd_a ^ opnd_b;
      OP_OR:   logic_res = opnd_a | opnd_b;
      OP_AND:  logic_res = opnd_a & opnd_b;
      OP_SET:  logic_res = {WIDTH{1'b1}};
      default: logic_res = '0;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit LOOKAHEAD = 1'b0
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       func_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf_out,
  output logic             grp_prop_n,
  output logic             grp_gen_n
);

  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             arith_en;
  logic [WIDTH-1:0] sum;
  logic             carry_top;
  logic             carry_msb_in;
  logic             grp_p;
  logic             grp_g;
  logic [WIDTH-1:0] logic_res;

  alu_slice_operand #(.WIDTH(WIDTH)) operand_i (
    .func_sel (func_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .add_x    (add_x),
    .add_y    (add_y),
    .arith_en (arith_en)
  );

  alu_slice_adder #(.WIDTH(WIDTH)) adder_i (
    .add_x        (add_x),
    .add_y        (add_y),
    .cin          (carry_in),
    .sum          (sum),
    .carry_top    (carry_top),
    .carry_msb_in (carry_msb_in),
    .grp_p        (grp_p),
    .grp_g        (grp_g)
  );

  alu_slice_logic #(.WIDTH(WIDTH)) logic_i (
    .func_sel  (func_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .logic_res (logic_res)
  );

  assign result = arith_en ? sum : logic_res;

  if (LOOKAHEAD) begin : g_lookahead
    assign grp_prop_n = ~(arith_en & grp_p);
    assign grp_gen_n  = ~(arith_en & grp_g);
    assign carry_out  = 1'b0;
    assign ovf_out    = 1'b0;
  end else begin : g_ripple
    assign grp_prop_n = 1'b1;
    assign grp_gen_n  = 1'b1;
    assign carry_out  = arith_en & carry_top;
    assign ovf_out    = arith_en & (carry_top ^ carry_msb_in);

    // R8
    always_comb begin
      ovf_sign_chk: assert (ovf_out == (arith_en && (add_x[WIDTH-1] == add_y[WIDTH-1])
                                        && (sum[WIDTH-1] != add_x[WIDTH-1])))
        else $error("overflow flag disagrees with sign rule");
    end
  end

  // R7
  always_comb begin
    if (!op_is_arith(func_sel)) begin
      quiet_flags_chk: assert (!carry_out && !ovf_out && grp_prop_n && grp_gen_n)
        else $error("cascade outputs active on a non-arithmetic code");
    end
  end

  // R6
  always_comb begin
    if (func_sel == OP_CLEAR || func_sel == OP_SET) begin
      const_result_chk: assert (result == {WIDTH{func_sel[0]}})
        else $error("constant code produced wrong result");
    end
  end

  // R5
  always_comb begin
    if (op_is_bitwise(func_sel)) begin
      bitwise_route_chk: assert (result == logic_res)
        else $error("bitwise code did not select the logic unit");
    end
  end

endmodule

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a, b;
  logic [2:0] sel;
  logic       cin;
  logic [3:0] f_rp, f_la;
  logic       co_rp, ov_rp, pn_rp, gn_rp;
  logic       co_la, ov_la, pn_la, gn_la;
  int         n_checks = 0;
  int         n_fails  = 0;
  bit         done     = 1'b0;

  always #10 clk = ~clk;

  alu_slice #(.WIDTH(4), .LOOKAHEAD(1'b0)) dut_i (
    .opnd_a(a), .opnd_b(b), .func_sel(sel), .carry_in(cin),
    .result(f_rp), .carry_out(co_rp), .ovf_out(ov_rp),
    .grp_prop_n(pn_rp), .grp_gen_n(gn_rp)
  );

  alu_slice #(.WIDTH(4), .LOOKAHEAD(1'b1)) dut_la_i (
    .opnd_a(a), .opnd_b(b), .func_sel(sel), .carry_in(cin),
    .result(f_la), .carry_out(co_la), .ovf_out(ov_la),
    .grp_prop_n(pn_la), .grp_gen_n(gn_la)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s sel=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               tag, sel, a, b, cin, act, exp);
    end
  endtask

  function automatic int sx4(input int v);
    return (v > 7) ? v - 16 : v;
  endfunction

  task automatic check_vector();
    int x, y, ef, s, ss, ec, eo, ep, eg;
    bit ar;
    string ftag;
    ar = (sel == 3'd1) || (sel == 3'd2) || (sel == 3'd3);
    x = 0; y = 0;
    case (sel)
      3'd1: begin x = b; y = 15 - a; ftag = "R2"; end
      3'd2: begin x = a; y = 15 - b; ftag = "R3"; end
      3'd3: begin x = a; y = b;      ftag = "R1"; end
      default: ftag = (sel == 3'd0 || sel == 3'd7) ? "R6" : "R5";
    endcase
    s = x + y + cin;
    case (sel)
      3'd0: ef = 0;
      3'd4: ef = a ^ b;
      3'd5: ef = a | b;
      3'd6: ef = a & b;
      3'd7: ef = 15;
      default: ef = s % 16;
    endcase
    ss = sx4(x) + sx4(y) + cin;
    ec = ar ? (s >= 16) : 0;
    eo = ar ? ((ss > 7) || (ss < -8)) : 0;
    eg = ar ? ((x + y) >= 16) : 0;
    ep = ar ? ((x | y) == 15) : 0;
    check(ftag, f_rp, ef);
    check(ftag, f_la, ef);
    check(ar ? "R4" : "R7", co_rp, ec);
    check(ar ? "R8" : "R7", ov_rp, eo);
    check(ar ? "R9" : "R7", gn_la, eg ? 0 : 1);
    check(ar ? "R10" : "R7", pn_la, ep ? 0 : 1);
    check("R11", {pn_rp, gn_rp, co_la, ov_la}, 4'b1100);
  endtask

  initial begin
    a = '0; b = '0; sel = 3'd0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R6", f_rp, 0);
    check("R7", {co_rp, ov_rp, pn_la, gn_la}, 4'b0011);
    for (int s_i = 0; s_i < 8; s_i++) begin
      for (int c_i = 0; c_i < 2; c_i++) begin
        for (int a_i = 0; a_i < 16; a_i++) begin
          for (int b_i = 0; b_i < 16; b_i++) begin
            @(negedge clk);
            sel = 3'(s_i); cin = c_i[0]; a = 4'(a_i); b = 4'(b_i);
            #2;
            check_vector();
          end
        end
      end
    end
    // R4: borrow corner cases spelled out
    @(negedge clk); sel = 3'd2; cin = 1'b1; a = 4'd5; b = 4'd5; #2;
    check("R4", co_rp, 1);
    @(negedge clk); a = 4'd4; b = 4'd5; #2;
    check("R4", co_rp, 0);
    // R8: both carry and overflow at once (-8 + -8)
    @(negedge clk); sel = 3'd3; cin = 1'b0; a = 4'd8; b = 4'd8; #2;
    check("R8", {co_rp, ov_rp}, 2'b11);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule